// File: doc/BRIEF.md
# UART FIFO control and status

This block is the buffering core of a memory-mapped serial port. It holds two byte queues of sixteen entries each. One carries bytes from the processor to the serial transmitter, and the other carries bytes from the serial receiver to the processor. The processor reaches the block through a small register bus. On that bus it writes one control word for each queue, reads a packed status word, writes outgoing bytes and reads incoming bytes. The serial side sees plain push and pop strobes.

Each control word enables its queue, can empty it in a single cycle, and sets a trigger level. The trigger level drives a level-sensitive service request toward the interrupt logic. A receive push that finds the queue full is dropped and reported on an overrun pulse. A disabled queue holds no data and takes none.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both queues are disabled. Both control words read 0 and the status word reads 0. rx_req, tx_req, tx_avail and rx_overrun are low.
- R2: Register addresses are 0 for transmit control, 1 for receive control, 2 for status, 3 for transmit data and 4 for receive data. In a control word, bit 0 is the queue enable, bit 1 is the flush command and bits 13:8 are the trigger level. Enable and trigger read back as written. The flush bit always reads 0.
- R3: The status word (address 2) carries the receive fill level in bits 5:0, the transmit fill level in bits 13:8 and the transmit free space in bits 29:24. Free space is 16 minus the transmit fill level while the transmit queue is enabled, and 0 while it is disabled. All other bits read 0.
- R4: A write to address 3 appends bits 7:0 of the write data to the transmit queue. tx_byte shows the oldest byte, and a tx_pop removes it, so bytes leave in the order they were written.
- R5: An rx_push stores rx_byte. A read of address 4 returns the oldest received byte in bits 7:0 and removes it. A read of address 4 while the receive queue is empty returns 0 and changes nothing.
- R6: A control write with bit 1 set empties that queue by the next cycle. The other queue is unaffected.
- R7: rx_req is high while the receive queue is enabled and its fill level is at or above its trigger level. tx_req is high while the transmit queue is enabled and its fill level is at or below its trigger level.
- R8: An rx_push while the receive queue holds 16 bytes, with no read in the same cycle, drops the byte. rx_overrun is then high for exactly the next cycle, and the stored bytes are unchanged.
- R9: While a queue is disabled its fill level reads 0, its stored bytes are discarded, and pushes to it are ignored. A disabled receive queue also raises no overrun.
- R10: A write to address 3 while the transmit queue holds 16 bytes is ignored.
- R11: tx_avail is high exactly when the transmit fill level is nonzero, so the transmitter counts as empty only at fill level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on receive data) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from current state |
| rx_push | input | 1 | Serial receiver delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_overrun | output | 1 | One-cycle pulse for a dropped receive byte |
| tx_pop | input | 1 | Serial transmitter takes the oldest byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |

## Verification
A wrong read or write pointer shows up as a byte order error. The bench sees it on tx_byte at the very next pop, or in receive data on the next read. A count that drifts shows in the status fields and in the two request lines in the cycle after the push or pop that caused it. That is the reason every scenario reads the status word back after each group of accesses. Flush and disable faults appear one cycle after the control write, as a nonzero fill level or a stray tx_avail.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
    localparam int BUS_W          = 32;
    localparam int ADDR_W         = 3;
    localparam int LVL_W          = 6;
    localparam int CTL_EN_BIT     = 0;
    localparam int CTL_FLUSH_BIT  = 1;
    localparam int CTL_LVL_LSB    = 8;
    localparam int STAT_RXF_LSB   = 0;
    localparam int STAT_TXF_LSB   = 8;
    localparam int STAT_FREE_LSB  = 24;

    typedef enum logic [ADDR_W-1:0] {
        REG_TXCTL = 3'd0,
        REG_RXCTL = 3'd1,
        REG_STAT  = 3'd2,
        REG_TXDAT = 3'd3,
        REG_RXDAT = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_pop  = pop && (st_q.cnt != '0) && !clear;
        do_push = push && !clear && ((st_q.cnt != CNT_W'(DEPTH)) || do_pop);
        st_d    = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = ptr_next(st_q.wr);
            if (do_pop)  st_d.rd = ptr_next(st_q.rd);
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= din;
    end

    assign dout  = mem[st_q.rd];
    assign count = st_q.cnt;
endmodule

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
    import ufc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    output logic             fifo_en,
    output logic [LVL_W-1:0] trig_lvl,
    output logic             flush,
    output logic [BUS_W-1:0] rdata
);
    typedef struct packed {
        logic             en;
        logic [LVL_W-1:0] lvl;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic unused_wdata;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.en  = wdata[CTL_EN_BIT];
            ctl_d.lvl = wdata[CTL_LVL_LSB +: LVL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // flush is a command only; it is not stored, so it reads back as 0
    assign flush = wr_en && wdata[CTL_FLUSH_BIT];

    always_comb begin
        rdata = '0;
        rdata[CTL_EN_BIT] = ctl_q.en;
        rdata[CTL_LVL_LSB +: LVL_W] = ctl_q.lvl;
    end

    assign fifo_en      = ctl_q.en;
    assign trig_lvl     = ctl_q.lvl;
    assign unused_wdata = ^wdata;
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import ufc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_overrun,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_avail,
    output logic              rx_req,
    output logic              tx_req
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic ovr;
    } top_st_t;

    top_st_t st_q, st_d;

    logic             tx_ctl_wr, rx_ctl_wr;
    logic             tx_en, rx_en, tx_flush, rx_flush;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic [BUS_W-1:0] tx_ctl_rd, rx_ctl_rd;
    logic             tx_push_sw, rx_pop_sw, rx_push_hw, tx_pop_hw;
    logic             tx_clear, rx_clear;
    logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_level, rx_level, tx_free;
    logic [DATA_W-1:0] rx_head;
    logic [BUS_W-1:0] stat_word;
    logic             unused_wbits;

    // ---------------- access decode ----------------
    always_comb begin
        tx_ctl_wr  = bus_wr && (bus_addr == REG_TXCTL);
        rx_ctl_wr  = bus_wr && (bus_addr == REG_RXCTL);
        tx_push_sw = bus_wr && (bus_addr == REG_TXDAT) && tx_en;
        rx_pop_sw  = bus_rd && (bus_addr == REG_RXDAT) && rx_en;
        rx_push_hw = rx_push && rx_en;
        tx_pop_hw  = tx_pop && tx_en;
        tx_clear   = tx_flush || !tx_en;
        rx_clear   = rx_flush || !rx_en;
    end

    ufc_ctl_reg u_tx_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tx_ctl_wr),
        .wdata    (bus_wdata),
        .fifo_en  (tx_en),
        .trig_lvl (tx_lvl),
        .flush    (tx_flush),
        .rdata    (tx_ctl_rd)
    );

    ufc_ctl_reg u_rx_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rx_ctl_wr),
        .wdata    (bus_wdata),
        .fifo_en  (rx_en),
        .trig_lvl (rx_lvl),
        .flush    (rx_flush),
        .rdata    (rx_ctl_rd)
    );

    ufc_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tx_clear),
        .push  (tx_push_sw),
        .pop   (tx_pop_hw),
        .din   (bus_wdata[DATA_W-1:0]),
        .dout  (tx_byte),
        .count (tx_cnt)
    );

    ufc_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rx_clear),
        .push  (rx_push_hw),
        .pop   (rx_pop_sw),
        .din   (rx_byte),
        .dout  (rx_head),
        .count (rx_cnt)
    );

    // ---------------- levels and status ----------------
    always_comb begin
        tx_level = tx_en ? tx_cnt : '0;
        rx_level = rx_en ? rx_cnt : '0;
        tx_free  = tx_en ? (CNT_W'(DEPTH) - tx_cnt) : '0;
        stat_word = '0;
        stat_word[STAT_RXF_LSB  +: LVL_W] = LVL_W'(rx_level);
        stat_word[STAT_TXF_LSB  +: LVL_W] = LVL_W'(tx_level);
        stat_word[STAT_FREE_LSB +: LVL_W] = LVL_W'(tx_free);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                REG_TXCTL: bus_rdata = tx_ctl_rd;
                REG_RXCTL: bus_rdata = rx_ctl_rd;
                REG_STAT:  bus_rdata = stat_word;
                REG_RXDAT: bus_rdata = (rx_level != '0) ? BUS_W'(rx_head) : '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // ---------------- overrun pulse ----------------
    always_comb begin
        st_d     = st_q;
        st_d.ovr = rx_push_hw && !rx_flush && (rx_cnt == CNT_W'(DEPTH)) && !rx_pop_sw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_overrun   = st_q.ovr;
    assign tx_avail     = tx_level != '0;
    assign rx_req       = rx_en && (LVL_W'(rx_level) >= rx_lvl);
    assign tx_req       = tx_en && (LVL_W'(tx_level) <= tx_lvl);
    assign unused_wbits = ^bus_wdata;
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              tx_en,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic              rx_flush,
    input logic              tx_flush,
    input logic              rx_push,
    input logic              rx_overrun,
    input logic              rx_req,
    input logic              tx_req,
    input logic              tx_avail,
    input logic              tx_pop,
    input logic [DATA_W-1:0] tx_byte
);
    assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(rx_push) && $past(rx_en)));

    assert_rx_req_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req |-> rx_en);

    assert_tx_req_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> tx_en);

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_flush) || $past(rx_flush)) |->
            (($past(tx_flush) -> tx_cnt == '0) && ($past(rx_flush) -> rx_cnt == '0)));

    assert_disabled_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rx_en) |-> rx_cnt == '0) and ($past(!tx_en) |-> tx_cnt == '0));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

    assert_head_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_avail) && tx_avail && !$past(tx_pop)) |-> $stable(tx_byte));
endmodule

bind uart_fifo_ctrl ufc_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .tx_en      (tx_en),
    .rx_cnt     (rx_cnt),
    .tx_cnt     (tx_cnt),
    .rx_flush   (rx_flush),
    .tx_flush   (tx_flush),
    .rx_push    (rx_push),
    .rx_overrun (rx_overrun),
    .rx_req     (rx_req),
    .tx_req     (tx_req),
    .tx_avail   (tx_avail),
    .tx_pop     (tx_pop),
    .tx_byte    (tx_byte)
);

// File: tb/uart_fifo_ctrl_test.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_overrun;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_avail, rx_req, tx_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_fifo_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_overrun(rx_overrun),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail),
        .rx_req(rx_req), .tx_req(tx_req)
    );

    localparam logic [2:0] A_TXCTL = 3'd0, A_RXCTL = 3'd1, A_STAT = 3'd2,
                           A_TXDAT = 3'd3, A_RXDAT = 3'd4;

    function automatic logic [31:0] stat(input int rxf, input int txf, input int fr);
        return (32'(fr) << 24) | (32'(txf) << 8) | 32'(rxf);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        rx_push = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(A_TXCTL, d); chk("R1 tx ctl", d, 0);
        bus_read(A_RXCTL, d); chk("R1 rx ctl", d, 0);
        bus_read(A_STAT, d);  chk("R1 status", d, 0);
        chk("R1 outputs", {28'd0, rx_req, tx_req, tx_avail, rx_overrun}, 0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        bus_write(A_TXCTL, 32'h0000_0503);
        bus_read(A_TXCTL, d); chk("R2 tx ctl readback, flush reads 0", d, 32'h0000_0501);
        bus_write(A_RXCTL, 32'h0000_0301);
        bus_read(A_RXCTL, d); chk("R2 rx ctl readback", d, 32'h0000_0301);
        bus_read(A_STAT, d);  chk("R3 empty enabled status", d, stat(0, 0, 16));
    endtask

    task automatic t_tx_basic();
        logic [31:0] d;
        bus_write(A_TXDAT, 32'hFFFF_FFA1);
        bus_write(A_TXDAT, 32'h0000_00B2);
        bus_write(A_TXDAT, 32'h0000_00C3);
        bus_read(A_STAT, d); chk("R3 tx fill 3 free 13", d, stat(0, 3, 13));
        chk("R11 tx_avail with data", 32'(tx_avail), 1);
        chk("R4 head byte", 32'(tx_byte), 32'hA1);
        chk("R7 tx_req fill 3 trig 5", 32'(tx_req), 1);
        pop_tx(); chk("R4 second byte", 32'(tx_byte), 32'hB2);
        pop_tx(); chk("R4 third byte", 32'(tx_byte), 32'hC3);
        pop_tx(); chk("R11 tx_avail empty", 32'(tx_avail), 0);
        for (int i = 0; i < 6; i++) bus_write(A_TXDAT, 32'(i));
        chk("R7 tx_req fill 6 above trig 5", 32'(tx_req), 0);
        pop_tx(); chk("R7 tx_req fill 5 equals trig", 32'(tx_req), 1);
        bus_write(A_TXCTL, 32'h0000_0503);
        bus_read(A_STAT, d); chk("R6 tx flush empties", d, stat(0, 0, 16));
        chk("R6 tx_avail after flush", 32'(tx_avail), 0);
    endtask

    task automatic t_rx_basic();
        logic [31:0] d;
        push_rx(8'h11); push_rx(8'h22);
        chk("R7 rx_req fill 2 below trig 3", 32'(rx_req), 0);
        push_rx(8'h33);
        chk("R7 rx_req fill 3 at trig", 32'(rx_req), 1);
        bus_read(A_STAT, d);  chk("R3 rx fill field", d, stat(3, 0, 16));
        bus_read(A_RXDAT, d); chk("R5 first rx byte", d, 32'h11);
        bus_read(A_RXDAT, d); chk("R5 second rx byte", d, 32'h22);
        chk("R7 rx_req fill 1", 32'(rx_req), 0);
        bus_read(A_RXDAT, d); chk("R5 third rx byte", d, 32'h33);
        bus_read(A_RXDAT, d); chk("R5 empty read returns 0", d, 0);
        bus_read(A_STAT, d);  chk("R5 empty read leaves level", d, stat(0, 0, 16));
    endtask

    task automatic t_tx_full();
        logic [31:0] d;
        for (int i = 0; i < 16; i++) bus_write(A_TXDAT, 32'h40 + 32'(i));
        bus_read(A_STAT, d); chk("R3 tx full free 0", d, stat(0, 16, 0));
        bus_write(A_TXDAT, 32'h99);
        bus_read(A_STAT, d); chk("R10 write when full ignored", d, stat(0, 16, 0));
        for (int i = 0; i < 16; i++) begin
            chk("R10 R4 drained order", 32'(tx_byte), 32'h40 + 32'(i));
            pop_tx();
        end
        chk("R10 no extra byte", 32'(tx_avail), 0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        for (int i = 0; i < 16; i++) push_rx(8'h60 + 8'(i));
        chk("R8 no overrun when filling", 32'(rx_overrun), 0);
        @(negedge clk); rx_push = 1'b1; rx_byte = 8'hEE;
        @(negedge clk); rx_push = 1'b0;
        chk("R8 overrun pulse", 32'(rx_overrun), 1);
        @(negedge clk);
        chk("R8 overrun one cycle", 32'(rx_overrun), 0);
        bus_read(A_STAT, d); chk("R8 level stays 16", d, stat(16, 0, 16));
        for (int i = 0; i < 16; i++) begin
            bus_read(A_RXDAT, d);
            chk("R8 stored bytes intact", d, 32'h60 + 32'(i));
        end
        bus_read(A_RXDAT, d); chk("R8 dropped byte absent", d, 0);
    endtask

    task automatic t_flush_indep();
        logic [31:0] d;
        push_rx(8'h5A);
        bus_write(A_TXDAT, 32'h01); bus_write(A_TXDAT, 32'h02);
        bus_write(A_RXCTL, 32'h0000_0303);
        bus_read(A_STAT, d); chk("R6 rx flush leaves tx", d, stat(0, 2, 14));
        bus_read(A_RXCTL, d); chk("R2 rx flush reads 0", d, 32'h0000_0301);
        bus_write(A_TXCTL, 32'h0000_0503);
        bus_read(A_STAT, d); chk("R6 tx flush", d, stat(0, 0, 16));
    endtask

    task automatic t_disable();
        logic [31:0] d;
        push_rx(8'h71); push_rx(8'h72);
        bus_write(A_RXCTL, 32'h0000_0300);
        bus_read(A_STAT, d); chk("R9 disabled rx level 0", d, stat(0, 0, 16));
        push_rx(8'h77);
        chk("R9 no overrun when disabled", 32'(rx_overrun), 0);
        bus_write(A_RXCTL, 32'h0000_0301);
        bus_read(A_STAT, d); chk("R9 rx push ignored and data discarded", d, stat(0, 0, 16));
        bus_read(A_RXDAT, d); chk("R9 rx empty after enable", d, 0);
        bus_write(A_TXCTL, 32'h0000_0500);
        bus_read(A_STAT, d); chk("R9 disabled tx free 0", d, 0);
        chk("R7 tx_req low when disabled", 32'(tx_req), 0);
        bus_write(A_TXDAT, 32'h88);
        bus_write(A_TXCTL, 32'h0000_0501);
        chk("R9 tx write ignored", 32'(tx_avail), 0);
        bus_read(A_STAT, d); chk("R9 tx level after enable", d, stat(0, 0, 16));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_tx_basic();
        t_rx_basic();
        t_tx_full();
        t_overrun();
        t_flush_indep();
        t_disable();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule